// File: doc/BRIEF.md
# Return-to-Zero Packet Steering Switch

This block joins several incoming serial links to four outgoing links. Each link carries one symbol at a time on four data wires, of which exactly one is high for a valid symbol (two bits per symbol). A separate end wire marks the close of a packet, and a single acknowledge runs back toward the sender. Every transfer is four-phase. The sender raises a symbol. The receiver raises the acknowledge. The sender drops to the all-zero spacer. The receiver then drops the acknowledge. The block models this link style with synchronous logic, with every wire sampled on the clock.

The first data symbol of each packet is a route. Its value picks one of the four outgoing links, and it is consumed rather than forwarded. The remaining symbols, up to and including the end marker, go to the chosen output in order. When several inputs want the same output, a round-robin arbiter chooses one between packets. That input keeps the output until its end marker has been sent, so packets are never split or mixed. Malformed code words are reported, acknowledged and dropped.

Top module: `ps_switch`

## Requirements
- R1: Code words on a link are {end, data[3:0]}. A data symbol has exactly one data wire high and end low, and its value is the index of that wire (wire k means value k). An end marker has end high and all data wires low. The spacer is all wires low. Every symbol the block drives on an output is one of these legal forms.
- R2: The first data symbol of a packet selects the output whose index equals its value. It is acknowledged and never appears on any output.
- R3: The symbols after the route, including the end marker, appear unchanged and in order on the selected output.
- R4: An input's acknowledge rises after a non-spacer code word is accepted. It stays high until the spacer is observed on that input, and only then falls. No further symbol is taken from that input while the acknowledge is high.
- R5: An output symbol is held stable until that output's acknowledge is high. The output then returns to the spacer, and the next symbol is driven only after the acknowledge has been seen low.
- R6: A code word with two or more data wires high, or with end high together with any data wire, raises that input's error output for exactly one cycle. The word is acknowledged and not forwarded, and the input's packet state is unchanged.
- R7: An end marker that arrives where a route is expected is acknowledged and discarded. Nothing is forwarded, and the next data symbol is again treated as a route.
- R8: Once an input wins an output, only that input's symbols are sent there until its end marker has gone out.
- R9: Among inputs waiting for a free output, the winner is the first requesting input found when searching upward, with wrap-around, from the index just after the previous winner on that output. After reset the search starts at input 0.
- R10: While reset is high and just after it, every output data and end wire, every acknowledge and every error output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | N_IN*4 | One-hot data wires of each input, input i at bits 4i+3..4i |
| rx_eop | input | N_IN | End-of-packet wire of each input |
| rx_ack | output | N_IN | Acknowledge back to each input's sender |
| rx_err | output | N_IN | One-cycle pulse per malformed code word |
| tx_data | output | 16 | One-hot data wires of each of the four outputs |
| tx_eop | output | 4 | End-of-packet wire of each output |
| tx_ack | input | 4 | Acknowledge from each output's receiver |

## Verification
The bench builds the switch with three inputs. A count that is not a power of two makes the round-robin pointer wrap from input 2 to input 0 rather than roll over a full binary range. With three inputs on one output, the expected grant order after a known previous winner (1, then 2, then 0) differs from what a fixed-priority arbiter would give. All four route values are used, so every output path and every decoding of a route wire is exercised.

// File: rtl/ps_pkg.sv
package ps_pkg;
  localparam int SYM_W = 4;
  localparam int RT_W  = 2;
  localparam int N_OUT = 1 << RT_W;

  typedef enum logic [1:0] {CW_SPACER, CW_DATA, CW_END, CW_BAD} cw_kind_e;

  function automatic cw_kind_e classify(input logic [SYM_W-1:0] d, input logic e);
    if (d == '0) return e ? CW_END : CW_SPACER;
    if (!e && $onehot(d)) return CW_DATA;
    return CW_BAD;
  endfunction

  function automatic logic [RT_W-1:0] wire_index(input logic [SYM_W-1:0] d);
    logic [RT_W-1:0] idx;
    idx = '0;
    for (int k = 0; k < SYM_W; k++)
      if (d[k]) idx = RT_W'(k);
    return idx;
  endfunction
endpackage

// File: rtl/ps_link_rx.sv
module ps_link_rx
  import ps_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] rx_data,
  input  logic             rx_eop,
  output logic             rx_ack,
  output logic             rx_err,
  output logic [RT_W-1:0]  route,
  output logic             in_body,
  output logic             ready,
  output logic [SYM_W-1:0] sym_data,
  output logic             sym_eop,
  input  logic             taken
);
  cw_kind_e kind;
  assign kind = classify(rx_data, rx_eop);

  assign ready    = in_body && !rx_ack && (kind == CW_DATA || kind == CW_END);
  assign sym_data = rx_data;
  assign sym_eop  = rx_eop;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ack  <= 1'b0;
      rx_err  <= 1'b0;
      in_body <= 1'b0;
      route   <= '0;
    end else begin
      rx_err <= 1'b0;
      if (rx_ack) begin
        // hold acknowledge until the spacer returns
        if (kind == CW_SPACER) rx_ack <= 1'b0;
      end else begin
        case (kind)
          CW_BAD: begin
            rx_ack <= 1'b1;
            rx_err <= 1'b1;
          end
          CW_DATA: begin
            if (!in_body) begin
              route   <= wire_index(rx_data);
              in_body <= 1'b1;
              rx_ack  <= 1'b1;
            end else if (taken) begin
              rx_ack <= 1'b1;
            end
          end
          CW_END: begin
            if (!in_body) begin
              rx_ack <= 1'b1;
            end else if (taken) begin
              rx_ack  <= 1'b1;
              in_body <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ps_rr_arb.sv
module ps_rr_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          release_i,
  output logic          locked,
  output logic [IW-1:0] owner
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] pick;
  logic          found;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      int cand;
      cand = (int'(ptr) + k) % N;
      if (!found && req[cand]) begin
        found = 1'b1;
        pick  = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      owner  <= '0;
      ptr    <= '0;
    end else if (locked) begin
      if (release_i) locked <= 1'b0;
    end else if (found) begin
      locked <= 1'b1;
      owner  <= pick;
      ptr    <= (int'(pick) == N - 1) ? '0 : pick + 1'b1;
    end
  end
endmodule

// File: rtl/ps_link_tx.sv
module ps_link_tx
  import ps_pkg::*;
#(
  parameter int N_IN = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_IN-1:0]       req,
  input  logic [N_IN-1:0]       ready,
  input  logic [N_IN*SYM_W-1:0] sym_data,
  input  logic [N_IN-1:0]       sym_eop,
  output logic [N_IN-1:0]       take,
  output logic [SYM_W-1:0]      tx_data,
  output logic                  tx_eop,
  input  logic                  tx_ack
);
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;

  typedef enum logic [1:0] {TX_IDLE, TX_HOLD, TX_RTZ} tx_st_e;
  tx_st_e st;

  logic          locked;
  logic [IW-1:0] owner;
  logic          load;
  logic          rel;

  ps_rr_arb #(.N(N_IN)) u_arb (
    .clk(clk), .rst(rst), .req(req), .release_i(rel),
    .locked(locked), .owner(owner)
  );

  assign load = locked && (st == TX_IDLE) && ready[owner];
  assign rel  = load && sym_eop[owner];

  always_comb begin
    take = '0;
    if (load) take[owner] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= TX_IDLE;
      tx_data <= '0;
      tx_eop  <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: if (load) begin
          tx_data <= sym_data[int'(owner)*SYM_W +: SYM_W];
          tx_eop  <= sym_eop[owner];
          st      <= TX_HOLD;
        end
        TX_HOLD: if (tx_ack) begin
          tx_data <= '0;
          tx_eop  <= 1'b0;
          st      <= TX_RTZ;
        end
        TX_RTZ: if (!tx_ack) st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps_switch.sv
module ps_switch
  import ps_pkg::*;
#(
  parameter int N_IN = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_IN*SYM_W-1:0]  rx_data,
  input  logic [N_IN-1:0]        rx_eop,
  output logic [N_IN-1:0]        rx_ack,
  output logic [N_IN-1:0]        rx_err,
  output logic [N_OUT*SYM_W-1:0] tx_data,
  output logic [N_OUT-1:0]       tx_eop,
  input  logic [N_OUT-1:0]       tx_ack
);
  logic [RT_W-1:0]          route [N_IN];
  logic [N_IN-1:0]          in_body;
  logic [N_IN-1:0]          ready;
  logic [N_IN*SYM_W-1:0]    sym_data;
  logic [N_IN-1:0]          sym_eop;
  logic [N_IN-1:0]          taken;
  logic [N_OUT-1:0][N_IN-1:0] want;
  logic [N_OUT-1:0][N_IN-1:0] take_m;

  for (genvar i = 0; i < N_IN; i++) begin : g_rx
    ps_link_rx u_rx (
      .clk(clk), .rst(rst),
      .rx_data(rx_data[i*SYM_W +: SYM_W]), .rx_eop(rx_eop[i]),
      .rx_ack(rx_ack[i]), .rx_err(rx_err[i]),
      .route(route[i]), .in_body(in_body[i]), .ready(ready[i]),
      .sym_data(sym_data[i*SYM_W +: SYM_W]), .sym_eop(sym_eop[i]),
      .taken(taken[i])
    );
  end

  always_comb begin
    for (int j = 0; j < N_OUT; j++)
      for (int i = 0; i < N_IN; i++)
        want[j][i] = in_body[i] && (int'(route[i]) == j);
  end

  always_comb begin
    taken = '0;
    for (int j = 0; j < N_OUT; j++) taken = taken | take_m[j];
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_tx
    ps_link_tx #(.N_IN(N_IN)) u_tx (
      .clk(clk), .rst(rst),
      .req(want[j]), .ready(ready), .sym_data(sym_data), .sym_eop(sym_eop),
      .take(take_m[j]),
      .tx_data(tx_data[j*SYM_W +: SYM_W]), .tx_eop(tx_eop[j]), .tx_ack(tx_ack[j])
    );
  end
endmodule

// File: rtl/ps_switch_chk.sv
module ps_switch_chk
  import ps_pkg::*;
#(
  parameter int N_IN = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_IN*SYM_W-1:0]  rx_data,
  input logic [N_IN-1:0]        rx_eop,
  input logic [N_IN-1:0]        rx_ack,
  input logic [N_IN-1:0]        rx_err,
  input logic [N_OUT*SYM_W-1:0] tx_data,
  input logic [N_OUT-1:0]       tx_eop,
  input logic [N_OUT-1:0]       tx_ack
);
  for (genvar i = 0; i < N_IN; i++) begin : g_in
    // R4: acknowledge drops only after a spacer was sampled
    a_r4_ack_fall_on_spacer: assert property (@(posedge clk) disable iff (rst)
      $fell(rx_ack[i]) |-> $past(rx_data[i*SYM_W +: SYM_W] == '0 && !rx_eop[i]));
    // R4: acknowledge rises only for a non-spacer code word
    a_r4_ack_rise_on_word: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_ack[i]) |-> $past(rx_data[i*SYM_W +: SYM_W] != '0 || rx_eop[i]));
    // R6: an error pulse comes with a fresh acknowledge
    a_r6_err_acked: assert property (@(posedge clk) disable iff (rst)
      rx_err[i] |-> (rx_ack[i] && !$past(rx_ack[i])));
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    // R1: output code words are always legal
    a_r1_tx_legal: assert property (@(posedge clk) disable iff (rst)
      $onehot0(tx_data[j*SYM_W +: SYM_W]) && !(tx_eop[j] && tx_data[j*SYM_W +: SYM_W] != '0));
    // R5: a symbol is held until acknowledged
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      ((tx_data[j*SYM_W +: SYM_W] != '0 || tx_eop[j]) && !tx_ack[j])
      |=> ($stable(tx_data[j*SYM_W +: SYM_W]) && $stable(tx_eop[j])));
    // R5: a new symbol starts only with the acknowledge low
    a_r5_new_after_low: assert property (@(posedge clk) disable iff (rst)
      ((tx_data[j*SYM_W +: SYM_W] != '0 || tx_eop[j]) &&
       $past(tx_data[j*SYM_W +: SYM_W] == '0 && !tx_eop[j])) |-> !$past(tx_ack[j]));
  end
endmodule

bind ps_switch ps_switch_chk #(.N_IN(N_IN)) u_chk (.*);

// File: tb/tb_ps_switch.sv
module tb_ps_switch;
  localparam int N_IN = 3;
  localparam int NO   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN*4-1:0] rx_data = '0;
  logic [N_IN-1:0]   rx_eop  = '0;
  logic [N_IN-1:0]   rx_ack;
  logic [N_IN-1:0]   rx_err;
  logic [NO*4-1:0]   tx_data;
  logic [NO-1:0]     tx_eop;
  logic [NO-1:0]     tx_ack = '0;

  int checks = 0;
  int errors = 0;
  logic [4:0] olog [NO][64];
  int ocnt [NO];
  int err_cnt [N_IN];

  always #4 clk = ~clk;

  ps_switch #(.N_IN(N_IN)) dut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_eop(rx_eop),
    .rx_ack(rx_ack), .rx_err(rx_err), .tx_data(tx_data), .tx_eop(tx_eop),
    .tx_ack(tx_ack)
  );

  always @(negedge clk)
    for (int i = 0; i < N_IN; i++) if (!rst && rx_err[i]) err_cnt[i]++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] dsym(input logic [1:0] v);
    return {1'b0, 4'b0001 << v};
  endfunction

  task automatic responder(input int j);
    forever begin
      @(negedge clk);
      if (tx_data[j*4 +: 4] != '0 || tx_eop[j]) begin
        if (ocnt[j] < 64) olog[j][ocnt[j]] = {tx_eop[j], tx_data[j*4 +: 4]};
        ocnt[j]++;
        repeat (2) @(negedge clk);
        tx_ack[j] = 1'b1;
        while (tx_data[j*4 +: 4] != '0 || tx_eop[j]) @(negedge clk);
        tx_ack[j] = 1'b0;
      end
    end
  endtask

  task automatic send_sym(input int i, input logic [4:0] c);
    @(negedge clk);
    rx_data[i*4 +: 4] = c[3:0];
    rx_eop[i] = c[4];
    while (!rx_ack[i]) @(negedge clk);
    rx_data[i*4 +: 4] = '0;
    rx_eop[i] = 1'b0;
    while (rx_ack[i]) @(negedge clk);
  endtask

  task automatic send_pkt(input int i, input logic [1:0] rt, input logic [15:0] pl, input int n);
    send_sym(i, dsym(rt));
    for (int k = 0; k < n; k++) send_sym(i, dsym(pl[2*k +: 2]));
    send_sym(i, 5'b10000);
  endtask

  task automatic check_pkt(input int j, input int base, input logic [15:0] pl,
                           input int n, input string req);
    int bad;
    bad = -1;
    for (int k = 0; k < n; k++)
      if (olog[j][base+k] != dsym(pl[2*k +: 2]) && bad < 0) bad = k;
    if (bad < 0 && olog[j][base+n] != 5'b10000) bad = n;
    if (bad >= 0)
      check(1'b0, req, $sformatf("out%0d symbol %0d", j, bad), int'(olog[j][base+bad]),
            bad == n ? 16 : int'(dsym(pl[2*bad +: 2])));
    else
      check(1'b1, req, "packet", 0, 0);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(tx_data == '0 && tx_eop == '0, "R10", "tx idle", int'(tx_data), 0);
    check(rx_ack == '0 && rx_err == '0, "R10", "rx ack/err", int'(rx_ack), 0);
  endtask

  task automatic t_single();
    int b;
    b = ocnt[2];
    send_pkt(0, 2'd2, 16'h0037, 3);
    settle();
    check(ocnt[2] == b + 4, "R2", "route stripped, count on out2", ocnt[2], b + 4);
    check_pkt(2, b, 16'h0037, 3, "R3");
    check(ocnt[0] == 0 && ocnt[1] == 0 && ocnt[3] == 0, "R2", "other outputs silent",
          ocnt[0] + ocnt[1] + ocnt[3], 0);
  endtask

  task automatic t_routes();
    int b0, b3;
    b0 = ocnt[0];
    b3 = ocnt[3];
    fork
      send_pkt(1, 2'd0, 16'h00E4, 4);
      send_pkt(2, 2'd3, 16'h001B, 4);
    join
    settle();
    check_pkt(0, b0, 16'h00E4, 4, "R3");
    check_pkt(3, b3, 16'h001B, 4, "R2");
  endtask

  task automatic t_contend();
    int b;
    send_pkt(0, 2'd1, 16'h0000, 1);
    settle();
    b = ocnt[1];
    fork
      send_pkt(0, 2'd1, 16'h0000, 2);
      send_pkt(1, 2'd1, 16'h0005, 2);
      send_pkt(2, 2'd1, 16'h000A, 2);
    join
    settle();
    check(ocnt[1] == b + 9, "R8", "symbol count on out1", ocnt[1], b + 9);
    check_pkt(1, b,     16'h0005, 2, "R9");
    check_pkt(1, b + 3, 16'h000A, 2, "R9");
    check_pkt(1, b + 6, 16'h0000, 2, "R8");
  endtask

  task automatic t_spacer();
    int b;
    b = ocnt[3];
    send_sym(0, dsym(2'd3));
    @(negedge clk);
    rx_data[3:0] = 4'b0010;
    while (!rx_ack[0]) @(negedge clk);
    rx_data[3:0] = 4'b0100;
    repeat (10) @(negedge clk);
    check(rx_ack[0] == 1'b1, "R4", "ack held without spacer", int'(rx_ack[0]), 1);
    check(ocnt[3] == b + 1, "R4", "no second symbol taken", ocnt[3], b + 1);
    rx_data[3:0] = 4'b0000;
    while (rx_ack[0]) @(negedge clk);
    send_sym(0, 5'b10000);
    settle();
    check_pkt(3, b, 16'h0001, 1, "R4");
  endtask

  task automatic t_error();
    int b, e;
    b = ocnt[0];
    e = err_cnt[2];
    send_sym(2, dsym(2'd0));
    send_sym(2, dsym(2'd2));
    send_sym(2, 5'b00011);
    send_sym(2, 5'b10001);
    send_sym(2, dsym(2'd3));
    send_sym(2, 5'b10000);
    settle();
    check(err_cnt[2] == e + 2, "R6", "error pulses", err_cnt[2], e + 2);
    check_pkt(0, b, 16'h000E, 2, "R6");
  endtask

  task automatic t_lone_end();
    int tot, b;
    tot = ocnt[0] + ocnt[1] + ocnt[2] + ocnt[3];
    send_sym(1, 5'b10000);
    settle();
    check(ocnt[0] + ocnt[1] + ocnt[2] + ocnt[3] == tot, "R7", "lone end not forwarded",
          ocnt[0] + ocnt[1] + ocnt[2] + ocnt[3], tot);
    b = ocnt[2];
    send_pkt(1, 2'd2, 16'h0006, 2);
    settle();
    check_pkt(2, b, 16'h0006, 2, "R7");
  endtask

  initial begin
    for (int j = 0; j < NO; j++) ocnt[j] = 0;
    for (int i = 0; i < N_IN; i++) err_cnt[i] = 0;
    for (int j = 0; j < NO; j++) begin
      automatic int jj = j;
      fork responder(jj); join_none
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_single();
    t_routes();
    t_contend();
    t_spacer();
    t_error();
    t_lone_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule